// File: doc/BRIEF.md
# Control-Structure Pointer Load Validator

This block decides the outcome of a request to install a new pointer to a virtual-machine control structure. A request arrives with a 64-bit candidate physical address and a snapshot of the processor mode: whether the operand came from a register, whether virtualization is switched on, protected-mode enable, the virtual-8086 flag, long-mode-active, the code-segment long bit, non-root mode and the current privilege level. The block walks a fixed priority chain of fault, exit and fail conditions. It returns exactly one result code, marked by a single-cycle done pulse.

When the mode checks and the address checks all pass, the block fetches the 32-bit revision word stored at the candidate address. It does this over a level request and valid-response memory port and waits as long as the memory needs. If the revision word is acceptable, the held pointer register takes the address and its valid flag is set. Every other outcome leaves the held pointer alone. The physical-address width, the 32-bit address limit, the supported revision ID, the shadowing-support flag and the enable-region pointer are all supplied as inputs.

Top module: `cs_ptr_loader`

## Requirements
- R1: A request with a register operand, virtualization off, protected-mode enable 0, virtual-8086 flag 1, or long mode active with the code-segment long bit 0 ends with result 1 (undefined opcode). This check outranks every other outcome.
- R2: If no R1 condition holds and non-root mode is 1, the result is 2 (VM exit).
- R3: If neither R1 nor R2 applies and the privilege level is above 0, the result is 3 (general protection, error code 0).
- R4: After R1 to R3, an address with any of bits 11:0 set, or with any bit at or above the configured physical-address width set, ends with result 4 (invalid address).
- R5: When the 32-bit limit input is 1, any set bit in address bits 63:32 also ends with result 4.
- R6: An address that passes R4 and R5 but equals the enable-region pointer ends with result 5. An address failing both checks reports 4.
- R7: The memory read is issued only when R1 to R6 all pass. Its request stays high with a constant address, equal to the candidate, until a response is accepted. Any number of wait cycles is allowed.
- R8: A revision word whose bits 30:0 differ from the supported ID, or whose bit 31 is 1 while shadowing support is 0, ends with result 6. A bit 31 of 1 is accepted when shadowing support is 1.
- R9: An accepted revision word ends with result 0. The held pointer then becomes the candidate address and its valid flag reads 1.
- R10: Results 1 to 6 leave the held pointer and valid flag unchanged. Reset clears the valid flag, done and the memory request.
- R11: Done is high for exactly one cycle per accepted request. A request presented while a read is in flight, including in the response cycle, is dropped and produces no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, sampled when idle |
| opIsReg | input | 1 | Operand is a register |
| virtOn | input | 1 | Virtualization mode enabled |
| protEn | input | 1 | Protected-mode enable |
| v86Flag | input | 1 | Virtual-8086 flag |
| longActive | input | 1 | Long mode active |
| csLong | input | 1 | Code-segment long bit |
| nonRoot | input | 1 | Guest (non-root) mode |
| cpl | input | 2 | Current privilege level |
| candAddr | input | 64 | Candidate physical address |
| enablePtr | input | 64 | Stored enable-region pointer |
| cfgPaWidth | input | 7 | Physical-address width in bits |
| cfgAddr32 | input | 1 | Limit addresses to 32 bits |
| cfgRevId | input | 31 | Supported revision ID |
| cfgShadowOk | input | 1 | Shadowing supported |
| memReq | output | 1 | Revision-word read request (level) |
| memAddr | output | 64 | Read address |
| memRspValid | input | 1 | Read response valid |
| memRspData | input | 32 | Revision word |
| busy | output | 1 | A read is in flight |
| done | output | 1 | One-cycle result strobe |
| result | output | 3 | Result code 0..6 |
| ptrValid | output | 1 | Held pointer valid |
| ptrAddr | output | 64 | Held pointer |

## Verification
Two things can land in the same cycle. One is the memory response that completes the in-flight check; the other is a fresh request, which must be dropped. The bench drives the response and a request that would fault together on one falling edge. It then expects one done with the revision outcome, followed by a quiet cycle with no second done. The priority chain is also provoked by setting several fault conditions at once, where only the highest-ranked code may appear.

// File: rtl/cs_ptr_pkg.sv
package cs_ptr_pkg;
  localparam logic [2:0] RES_OK      = 3'd0;
  localparam logic [2:0] RES_UD      = 3'd1;
  localparam logic [2:0] RES_EXIT    = 3'd2;
  localparam logic [2:0] RES_GP      = 3'd3;
  localparam logic [2:0] RES_BADADDR = 3'd4;
  localparam logic [2:0] RES_ENPTR   = 3'd5;
  localparam logic [2:0] RES_REV     = 3'd6;

  typedef enum logic {ST_IDLE, ST_WAIT} ctlState_e;

  typedef struct packed {
    logic capture;  // latch the candidate address, start a read
    logic finPre;   // finish with the pre-read code
    logic finRev;   // finish with the revision verdict
  } ctlStrobes_t;
endpackage

// File: rtl/cs_ptr_datapath.sv
module cs_ptr_datapath
  import cs_ptr_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int REV_W     = 32,
  parameter int PAGE_BITS = 12,
  parameter int LOW_LIMIT = 32,
  localparam int PAW_W    = $clog2(ADDR_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       str,
  input  logic              opIsReg,
  input  logic              virtOn,
  input  logic              protEn,
  input  logic              v86Flag,
  input  logic              longActive,
  input  logic              csLong,
  input  logic              nonRoot,
  input  logic [1:0]        cpl,
  input  logic [ADDR_W-1:0] candAddr,
  input  logic [ADDR_W-1:0] enablePtr,
  input  logic [PAW_W-1:0]  cfgPaWidth,
  input  logic              cfgAddr32,
  input  logic [REV_W-2:0]  cfgRevId,
  input  logic              cfgShadowOk,
  input  logic [REV_W-1:0]  memRspData,
  output logic              preFail,
  output logic [ADDR_W-1:0] memAddr,
  output logic              done,
  output logic [2:0]        result,
  output logic              ptrValid,
  output logic [ADDR_W-1:0] ptrAddr
);
  logic [ADDR_W-1:0] overMask;
  logic [2:0]        preCode;
  logic              udCond, misAligned, highBits, badAddr, revFail;
  logic [ADDR_W-1:0] latchedAddr;

  for (genvar g = 0; g < ADDR_W; g++) begin : g_width
    assign overMask[g] = candAddr[g] & (cfgPaWidth <= PAW_W'(g));
  end

  assign udCond     = opIsReg | ~virtOn | ~protEn | v86Flag | (longActive & ~csLong);
  assign misAligned = |candAddr[PAGE_BITS-1:0];
  assign highBits   = cfgAddr32 & (|candAddr[ADDR_W-1:LOW_LIMIT]);
  assign badAddr    = misAligned | (|overMask) | highBits;

  always_comb begin
    if (udCond)                     preCode = RES_UD;
    else if (nonRoot)               preCode = RES_EXIT;
    else if (cpl != 2'd0)           preCode = RES_GP;
    else if (badAddr)               preCode = RES_BADADDR;
    else if (candAddr == enablePtr) preCode = RES_ENPTR;
    else                            preCode = RES_OK;
  end
  assign preFail = (preCode != RES_OK);

  assign revFail = (memRspData[REV_W-2:0] != cfgRevId) |
                   (memRspData[REV_W-1] & ~cfgShadowOk);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done        <= 1'b0;
      result      <= RES_OK;
      ptrValid    <= 1'b0;
      ptrAddr     <= '0;
      latchedAddr <= '0;
    end else begin
      done <= str.finPre | str.finRev;
      if (str.capture) latchedAddr <= candAddr;
      if (str.finPre)  result <= preCode;
      if (str.finRev) begin
        result <= revFail ? RES_REV : RES_OK;
        if (!revFail) begin
          ptrAddr  <= latchedAddr;
          ptrValid <= 1'b1;
        end
      end
    end
  end
  assign memAddr = latchedAddr;

  p_fail_keeps_ptr_r10: assert property (@(posedge clk) disable iff (!rstN)
    (done && result != RES_OK) |-> ($stable(ptrAddr) && $stable(ptrValid)));
  p_ok_sets_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && result == RES_OK) |-> (ptrValid && ptrAddr == memAddr));
  p_code_range_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (result <= RES_REV));
endmodule

// File: rtl/cs_ptr_control.sv
module cs_ptr_control
  import cs_ptr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        preFail,
  input  logic        memRspValid,
  output ctlStrobes_t str,
  output logic        memReq,
  output logic        busy
);
  ctlState_e state, stateNext;

  always_comb begin
    str       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        if (preFail) str.finPre = 1'b1;
        else begin
          str.capture = 1'b1;
          stateNext   = ST_WAIT;
        end
      end
      ST_WAIT: if (memRspValid) begin
        str.finRev = 1'b1;
        stateNext  = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign memReq = (state == ST_WAIT);
  assign busy   = memReq;

  p_req_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRspValid) |=> memReq);
  p_read_after_checks_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) |-> $past(reqValid && !preFail));
  p_single_outcome_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(str.finPre && str.finRev));
endmodule

// File: rtl/cs_ptr_loader.sv
module cs_ptr_loader
  import cs_ptr_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int REV_W  = 32,
  localparam int PAW_W = $clog2(ADDR_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              opIsReg,
  input  logic              virtOn,
  input  logic              protEn,
  input  logic              v86Flag,
  input  logic              longActive,
  input  logic              csLong,
  input  logic              nonRoot,
  input  logic [1:0]        cpl,
  input  logic [ADDR_W-1:0] candAddr,
  input  logic [ADDR_W-1:0] enablePtr,
  input  logic [PAW_W-1:0]  cfgPaWidth,
  input  logic              cfgAddr32,
  input  logic [REV_W-2:0]  cfgRevId,
  input  logic              cfgShadowOk,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRspValid,
  input  logic [REV_W-1:0]  memRspData,
  output logic              busy,
  output logic              done,
  output logic [2:0]        result,
  output logic              ptrValid,
  output logic [ADDR_W-1:0] ptrAddr
);
  ctlStrobes_t str;
  logic        preFail;

  cs_ptr_control u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .preFail(preFail),
    .memRspValid(memRspValid), .str(str), .memReq(memReq), .busy(busy)
  );

  cs_ptr_datapath #(.ADDR_W(ADDR_W), .REV_W(REV_W)) u_dp (
    .clk(clk), .rstN(rstN), .str(str),
    .opIsReg(opIsReg), .virtOn(virtOn), .protEn(protEn), .v86Flag(v86Flag),
    .longActive(longActive), .csLong(csLong), .nonRoot(nonRoot), .cpl(cpl),
    .candAddr(candAddr), .enablePtr(enablePtr), .cfgPaWidth(cfgPaWidth),
    .cfgAddr32(cfgAddr32), .cfgRevId(cfgRevId), .cfgShadowOk(cfgShadowOk),
    .memRspData(memRspData), .preFail(preFail), .memAddr(memAddr),
    .done(done), .result(result), .ptrValid(ptrValid), .ptrAddr(ptrAddr)
  );
endmodule

// File: tb/tb_cs_ptr_loader.sv
module tb_cs_ptr_loader;
  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, opIsReg = 0, virtOn = 1, protEn = 1, v86Flag = 0;
  logic longActive = 0, csLong = 0, nonRoot = 0;
  logic [1:0] cpl = 0;
  logic [63:0] candAddr = 0, enablePtr = 64'h0000_0000_0010_0000;
  logic [6:0] cfgPaWidth = 7'd46;
  logic cfgAddr32 = 0, cfgShadowOk = 0;
  logic [30:0] cfgRevId = 31'h0000_1234;
  logic memReq, busy, done, ptrValid, memRspValid = 0;
  logic [63:0] memAddr, ptrAddr;
  logic [31:0] memRspData = 0;
  logic [2:0] result;

  int checks = 0, errors = 0;
  logic [63:0] expPtr = 0;
  logic expValid = 0;
  localparam logic [63:0] GOOD = 64'h0000_0012_3456_7000;
  localparam logic [31:0] REVOK = 32'h0000_1234;

  always #5 clk = ~clk;

  cs_ptr_loader dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setGood();
    opIsReg = 0; virtOn = 1; protEn = 1; v86Flag = 0; longActive = 0;
    csLong = 0; nonRoot = 0; cpl = 0; candAddr = GOOD; cfgAddr32 = 0; cfgShadowOk = 0;
  endtask

  // Drive one request; respond to a read after lat cycles with rev.
  task automatic runReq(input logic [2:0] exp, input logic [31:0] rev, input int lat, input string req);
    bit wantRead = (exp == 3'd0 || exp == 3'd6);
    reqValid = 1;
    @(negedge clk);
    reqValid = 0;
    chk(memReq == wantRead, {req, " read issued"}, memReq, wantRead);
    if (wantRead) begin
      chk(memAddr == candAddr, {req, " read address R7"}, memAddr, candAddr);
      chk(!done, {req, " no done before response"}, done, 0);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        chk(memReq && !done, {req, " request held R7"}, {memReq, done}, 2'b10);
      end
      memRspValid = 1; memRspData = rev;
      @(negedge clk);
      memRspValid = 0;
    end
    chk(done && result == exp, {req, " result"}, {done, result}, {1'b1, exp});
    if (exp == 3'd0) begin expPtr = candAddr; expValid = 1; end
    chk(ptrAddr == expPtr && ptrValid == expValid, {req, " pointer R10"}, ptrAddr, expPtr);
    @(negedge clk);
    chk(!done && !memReq, {req, " done pulse R11"}, {done, memReq}, 0);
  endtask

  task automatic tUndef();
    setGood(); opIsReg = 1; runReq(3'd1, 0, 0, "R1 register operand");
    setGood(); virtOn = 0;  runReq(3'd1, 0, 0, "R1 virt off");
    setGood(); protEn = 0;  runReq(3'd1, 0, 0, "R1 prot off");
    setGood(); v86Flag = 1; runReq(3'd1, 0, 0, "R1 v86");
    setGood(); longActive = 1; csLong = 0; runReq(3'd1, 0, 0, "R1 compat mode");
    setGood(); longActive = 1; csLong = 1; runReq(3'd0, REVOK, 1, "R1 64-bit mode passes");
    setGood(); v86Flag = 1; nonRoot = 1; cpl = 3; candAddr = 64'h1; runReq(3'd1, 0, 0, "R1 priority");
  endtask

  task automatic tExitGp();
    setGood(); nonRoot = 1; cpl = 2; runReq(3'd2, 0, 0, "R2 exit over gp");
    setGood(); cpl = 1; candAddr = 64'h5; runReq(3'd3, 0, 0, "R3 gp over addr");
  endtask

  task automatic tAddr();
    setGood(); candAddr = GOOD | 64'h800; runReq(3'd4, 0, 0, "R4 misaligned");
    setGood(); candAddr = 64'h0000_4000_0000_0000; runReq(3'd4, 0, 0, "R4 bit at width");
    setGood(); candAddr = 64'h0000_2000_0000_0000; runReq(3'd0, REVOK, 0, "R4 top legal bit");
    setGood(); cfgAddr32 = 1; candAddr = 64'h0000_0001_0000_0000; runReq(3'd4, 0, 0, "R5 limit set");
    setGood(); cfgAddr32 = 1; candAddr = 64'h0000_0000_8000_0000; runReq(3'd0, REVOK, 2, "R5 low ok");
    setGood(); candAddr = enablePtr; runReq(3'd5, 0, 0, "R6 enable ptr");
    setGood(); candAddr = enablePtr; enablePtr = enablePtr | 64'h4; candAddr = enablePtr;
    runReq(3'd4, 0, 0, "R6 invalid outranks");
    enablePtr = 64'h0000_0000_0010_0000;
  endtask

  task automatic tRev();
    setGood(); runReq(3'd6, 32'h0000_1235, 3, "R8 id mismatch");
    setGood(); runReq(3'd6, 32'h8000_1234, 0, "R8 shadow unsupported");
    setGood(); cfgShadowOk = 1; candAddr = 64'h0000_0000_0777_0000;
    runReq(3'd0, 32'h8000_1234, 5, "R8 shadow supported");
    setGood(); runReq(3'd0, REVOK, 7, "R9 success");
  endtask

  task automatic tCollide();
    setGood(); candAddr = 64'h0000_0000_0abc_d000;
    reqValid = 1;
    @(negedge clk);
    reqValid = 0;
    chk(busy, "R11 busy", busy, 1);
    opIsReg = 1; reqValid = 1;           // ignored: read in flight
    @(negedge clk);
    chk(!done && busy, "R11 request during wait", {done, busy}, 2'b01);
    memRspValid = 1; memRspData = REVOK; // response and request together
    @(negedge clk);
    memRspValid = 0; reqValid = 0;
    expPtr = 64'h0000_0000_0abc_d000; expValid = 1;
    chk(done && result == 3'd0, "R11 response wins", result, 0);
    chk(ptrAddr == expPtr, "R9 collide pointer", ptrAddr, expPtr);
    @(negedge clk);
    chk(!done, "R11 dropped request", done, 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    setGood();
    repeat (3) @(negedge clk);
    chk(!ptrValid && !done && !memReq, "R10 reset state", {ptrValid, done, memReq}, 0);
    rstN = 1;
    @(negedge clk);
    tUndef();
    tExitGp();
    tAddr();
    tRev();
    tCollide();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule